// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog peripheral on a plain register bus with an address, write data, a write strobe and combinational read data. Software turns the watchdog on through a control word. From then on a down-counter falls by one on every prescaled tick. Software must reload the counter before it runs out. It does so by writing one exact 16-bit key to the restart word. When the counter does run out, the block drives a system reset request for a fixed number of clocks and then drops it.

A one-way freeze bit protects the control word. Once freeze is set, every write to the control word has no effect: the enable, the prescaler choice and the status clear are all locked. Only the block's reset input clears freeze. Software can set freeze together with enable to make the watchdog permanent. It can also set freeze with enable low, which keeps the watchdog off until the next reset.

A write of any value other than the key leaves the counter alone and sets a sticky status bit. Reading the restart word returns the live counter value, so software can watch the countdown.

Top module: `kdw_top`

## Requirements
- R1: After reset the control word reads 0 (disabled, unfrozen, prescaler 0, no bad-key status), the restart word reads TIMEOUT_TICKS and the reset request is low.
- R2: While unfrozen, a write to offset 0x0 loads enable from bit 0, freeze from bit 1 and the prescaler select from bits 7:4, and these read back from the same bit positions.
- R3: While freeze is set, writes to offset 0x0 change nothing: not enable, not freeze, not the prescaler select, and not the bad-key status, even when bit 8 is 1.
- R4: Freeze stays set on every clock until the reset input is asserted; after reset it reads 0.
- R5: Reading offset 0x4 returns the counter value zero-extended; while enable is 0 the counter holds at TIMEOUT_TICKS.
- R6: While enabled with prescaler select p, the counter decreases by one every 2^p clocks.
- R7: A write of exactly 0x0000A5A5 to offset 0x4 reloads the counter to TIMEOUT_TICKS and restarts the prescaler phase; the reloaded value is readable after that clock edge.
- R8: A write of any other value to offset 0x4 leaves the counter running and sets the bad-key status at bit 8 of the control word; it stays set until a write to offset 0x0 with bit 8 set clears it while unfrozen.
- R9: When a tick arrives with the counter at 1 and no restart in the same cycle, the counter reloads to TIMEOUT_TICKS and the reset request goes high after that same edge.
- R10: The reset request stays high for exactly RST_HOLD consecutive clocks and then falls.
- R11: Writes to offsets other than 0x0 and 0x4 have no effect, and reads of them return 0.
- R12: With freeze set and enable 0, the counter stays at TIMEOUT_TICKS and no reset request is ever raised until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| sys_rst_req | output | 1 | System reset request |

## Verification
The assertions assume that the bus performs at most one write per clock, to a single decoded offset. A control write and a restart write therefore never land in the same cycle. The assertions also assume that TIMEOUT_TICKS is larger than RST_HOLD, so a new expiry cannot occur while a reset pulse is still being stretched. The stimulus issues one bus operation per clock through a single task. It always follows an expiry with a restart well before the counter could run out a second time. It raises the reset input only between operations.

// File: rtl/kdw_pkg.sv
package kdw_pkg;

   // Byte offsets decoded by the bus front end
   localparam int unsigned KDW_OFS_CTRL = 0;
   localparam int unsigned KDW_OFS_KICK = 4;

   // Restart key compared against the written data
   localparam logic [15:0] KDW_KEY = 16'hA5A5;

   // Width of the control image placed on the read bus
   localparam int unsigned KDW_CTRL_W = 9;

   // Prescaler phase counter covers a select of up to 15
   localparam int unsigned KDW_PRE_W = 16;

   typedef struct packed {
      logic       bad;   // bit 8
      logic [3:0] psel;  // bits 7:4
      logic       frz;   // bit 1
      logic       en;    // bit 0
   } kdw_ctrl_t;

endpackage

// File: rtl/kdw_regs.sv
module kdw_regs
   import kdw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic       bad_set,
   input  logic [8:0] wdata,
   output kdw_ctrl_t  ctrl
);

   kdw_ctrl_t ctrl_q;
   logic      wr_ok;

   assign wr_ok = ctrl_wr && !ctrl_q.frz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ok) begin
            ctrl_q.en   <= wdata[0];
            ctrl_q.frz  <= wdata[1];
            ctrl_q.psel <= wdata[7:4];
         end
         if (bad_set) begin
            ctrl_q.bad <= 1'b1;
         end else if (wr_ok && wdata[8]) begin
            ctrl_q.bad <= 1'b0;
         end
      end
   end

   assign ctrl = ctrl_q;

endmodule

// File: rtl/kdw_timebase.sv
module kdw_timebase
   import kdw_pkg::*;
#(
   parameter int unsigned TIMEOUT_TICKS = 4500,
   parameter int unsigned CNT_W         = $clog2(TIMEOUT_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [3:0]       psel,
   input  logic             kick,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT_TICKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [KDW_PRE_W-1:0] pre_q;
   logic [KDW_PRE_W-1:0] pre_lim;
   logic [CNT_W-1:0]     cnt_q;
   logic                 tick;

   assign pre_lim = (KDW_PRE_W'(1) << psel) - KDW_PRE_W'(1);
   assign tick    = en && (pre_q >= pre_lim);
   assign expire  = tick && !kick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!en || kick || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + KDW_PRE_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= LOAD;
      end else if (kick || !en) begin
         cnt_q <= LOAD;
      end else if (tick) begin
         cnt_q <= (cnt_q == LAST) ? LOAD : cnt_q - LAST;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/kdw_rstgen.sv
module kdw_rstgen #(
   parameter int unsigned RST_HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   output logic req
);

   localparam int unsigned HW = $clog2(RST_HOLD + 1);

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (expire) begin
         hold_q <= HW'(RST_HOLD);
      end else if (hold_q != '0) begin
         hold_q <= hold_q - HW'(1);
      end
   end

   assign req = (hold_q != '0);

endmodule

// File: rtl/kdw_top.sv
module kdw_top
   import kdw_pkg::*;
#(
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned TIMEOUT_TICKS = 4500,
   parameter int unsigned RST_HOLD      = 16,
   parameter bit          KEY_FULL_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_rst_req
);

   localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(KDW_OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(KDW_OFS_KICK);

   // Elaboration-time parameter checks
   if (ADDR_W < 3) begin : g_err_addr
      $error("kdw_top: ADDR_W must reach offset 4");
   end
   if (DATA_W < 16 || DATA_W < CNT_W) begin : g_err_data
      $error("kdw_top: DATA_W too narrow for key or counter");
   end
   if (TIMEOUT_TICKS < 2) begin : g_err_to
      $error("kdw_top: TIMEOUT_TICKS must be at least 2");
   end
   if (RST_HOLD < 1 || RST_HOLD >= TIMEOUT_TICKS) begin : g_err_hold
      $error("kdw_top: RST_HOLD must be in 1..TIMEOUT_TICKS-1");
   end

   kdw_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] cnt;
   logic             sel_ctrl;
   logic             sel_kick;
   logic             key_ok;
   logic             kick;
   logic             bad_set;
   logic             expire;

   assign sel_ctrl = (bus_addr == A_CTRL);
   assign sel_kick = (bus_addr == A_KICK);

   // Key match variant: whole word, or low half only
   if (KEY_FULL_WORD) begin : g_key_full
      assign key_ok = (bus_wdata == DATA_W'(KDW_KEY));
   end else begin : g_key_low
      assign key_ok = (bus_wdata[15:0] == KDW_KEY);
   end

   assign kick    = bus_we && sel_kick && key_ok;
   assign bad_set = bus_we && sel_kick && !key_ok;

   kdw_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (bus_we && sel_ctrl),
      .bad_set (bad_set),
      .wdata   (bus_wdata[8:0]),
      .ctrl    (ctrl_q)
   );

   kdw_timebase #(
      .TIMEOUT_TICKS (TIMEOUT_TICKS),
      .CNT_W         (CNT_W)
   ) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl_q.en),
      .psel   (ctrl_q.psel),
      .kick   (kick),
      .cnt    (cnt),
      .expire (expire)
   );

   kdw_rstgen #(
      .RST_HOLD (RST_HOLD)
   ) u_rg (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .req    (sys_rst_req)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata = DATA_W'({ctrl_q.bad, ctrl_q.psel, 2'b00, ctrl_q.frz, ctrl_q.en});
      end else if (sel_kick) begin
         bus_rdata = DATA_W'(cnt);
      end
   end

endmodule

// File: rtl/kdw_chk.sv
module kdw_chk
   import kdw_pkg::*;
#(
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned TIMEOUT_TICKS = 4500,
   parameter int unsigned RST_HOLD      = 16,
   parameter bit          KEY_FULL_WORD = 1'b1,
   parameter int unsigned CNT_W         = $clog2(TIMEOUT_TICKS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic              req,
   input logic              en,
   input logic              frz,
   input logic [3:0]        psel,
   input logic              bad,
   input logic [CNT_W-1:0]  cnt
);

   logic wr_ctrl;
   logic wr_kick;
   logic hit;
   int unsigned run_q;

   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(KDW_OFS_CTRL));
   assign wr_kick = bus_we && (bus_addr == ADDR_W'(KDW_OFS_KICK));
   assign hit = KEY_FULL_WORD ? (bus_wdata == DATA_W'(KDW_KEY))
                              : (bus_wdata[15:0] == KDW_KEY);

   // Length of the current run of request-high cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   run_q <= 0;
      else if (req) run_q <= run_q + 1;
      else          run_q <= 0;
   end

   assert_frozen_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && wr_ctrl) |=> ($stable(en) && $stable(frz) && $stable(psel) && $stable(bad)));

   assert_freeze_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frz |=> frz);

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == CNT_W'(TIMEOUT_TICKS)));

   assert_key_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kick && hit) |=> (cnt == CNT_W'(TIMEOUT_TICKS)));

   assert_bad_key_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kick && !hit) |=> bad);

   assert_req_from_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> ($past(cnt) == CNT_W'(1) && cnt == CNT_W'(TIMEOUT_TICKS)));

   assert_req_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> (run_q == RST_HOLD));

   assert_req_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RST_HOLD);

   assert_frozen_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && !en) |=> (!en && !$rose(req)));

endmodule

bind kdw_top kdw_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .TIMEOUT_TICKS (TIMEOUT_TICKS),
   .RST_HOLD      (RST_HOLD),
   .KEY_FULL_WORD (KEY_FULL_WORD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .req       (sys_rst_req),
   .en        (ctrl_q.en),
   .frz       (ctrl_q.frz),
   .psel      (ctrl_q.psel),
   .bad       (ctrl_q.bad),
   .cnt       (cnt)
);

// File: tb/tb_kdw_top.sv
module tb_kdw_top;

   localparam int AW = 4;
   localparam int DW = 32;
   localparam int TO = 20;
   localparam int HOLD = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          we = 1'b0;
   wire  [DW-1:0] rdata;
   wire           req;

   always #5 clk = ~clk;

   kdw_top #(
      .ADDR_W (AW), .DATA_W (DW), .TIMEOUT_TICKS (TO),
      .RST_HOLD (HOLD), .KEY_FULL_WORD (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_wdata (wdata),
      .bus_we (we), .bus_rdata (rdata), .sys_rst_req (req)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";

   // Behavioural reference state
   int m_en, m_frz, m_psel, m_bad, m_pre, m_cnt, m_hold;

   task automatic model_reset();
      m_en = 0; m_frz = 0; m_psel = 0; m_bad = 0;
      m_pre = 0; m_cnt = TO; m_hold = 0;
   endtask

   function automatic longint exp_rd(int a);
      if (a == 0) return (m_bad << 8) | (m_psel << 4) | (m_frz << 1) | m_en;
      if (a == 4) return m_cnt;
      return 0;
   endfunction

   task automatic model_step(int a, logic [31:0] d, bit w);
      bit kick, badw, cw, tick, exp_now;
      int n_en, n_frz, n_psel, n_bad, n_pre, n_cnt, n_hold;
      kick = w && a == 4 && d == 32'h0000A5A5;
      badw = w && a == 4 && !kick;
      cw   = w && a == 0 && m_frz == 0;
      tick = m_en != 0 && m_pre >= (1 << m_psel) - 1;
      exp_now = 0;
      n_pre = (m_en == 0 || kick || tick) ? 0 : m_pre + 1;
      n_cnt = m_cnt;
      if (kick || m_en == 0) n_cnt = TO;
      else if (tick) begin
         if (m_cnt == 1) begin n_cnt = TO; exp_now = 1; end
         else n_cnt = m_cnt - 1;
      end
      n_hold = exp_now ? HOLD : (m_hold > 0 ? m_hold - 1 : 0);
      n_en = m_en; n_frz = m_frz; n_psel = m_psel; n_bad = m_bad;
      if (cw) begin
         n_en = d[0]; n_frz = d[1]; n_psel = d[7:4];
         if (d[8]) n_bad = 0;
      end
      if (badw) n_bad = 1;
      m_en = n_en; m_frz = n_frz; m_psel = n_psel; m_bad = n_bad;
      m_pre = n_pre; m_cnt = n_cnt; m_hold = n_hold;
   endtask

   task automatic chk(string t, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   // One bus cycle, then compare against the model away from the edge
   task automatic cyc(int a, logic [31:0] d, bit w);
      addr = AW'(a); wdata = d; we = w;
      @(posedge clk);
      model_step(a, d, w);
      @(negedge clk);
      chk({tag, " req"}, req, (m_hold > 0) ? 1 : 0);
      chk({tag, " rdata"}, rdata, exp_rd(a));
      we = 1'b0;
   endtask

   task automatic idle(int n, int a);
      for (int i = 0; i < n; i++) cyc(a, 32'h0, 1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; we = 1'b0; addr = '0;
      repeat (2) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int hi_cnt;
      bit seen;
      do_reset();

      tag = "R1";
      cyc(0, 0, 0);
      chk("R1 ctrl after reset", rdata, 0);
      chk("R1 req after reset", req, 0);
      cyc(4, 0, 0);
      chk("R1 counter after reset", rdata, TO);

      tag = "R5";
      idle(5, 4);
      chk("R5 disabled counter holds", rdata, TO);

      tag = "R2";
      cyc(0, 32'h11, 1);
      cyc(0, 0, 0);
      chk("R2 ctrl readback", rdata, 32'h11);

      tag = "R6";
      idle(9, 4);
      tag = "R7";
      cyc(4, 32'h0000A5A5, 1);
      chk("R7 key reloads counter", rdata, TO);
      tag = "R6";
      idle(4, 4);
      chk("R6 two ticks at psel 1", rdata, TO - 2);

      tag = "R8";
      cyc(4, 32'h1234, 1);
      chk("R8 wrong key keeps counter", rdata, TO - 2);
      cyc(0, 0, 0);
      chk("R8 bad-key bit set", rdata, 32'h111);
      cyc(4, 32'h0001A5A5, 1);
      cyc(0, 32'h111, 1);
      chk("R8 bad-key cleared by write", rdata, 32'h011);

      tag = "R9";
      cyc(0, 32'h1, 1);
      hi_cnt = 0; seen = 0;
      for (int i = 0; i < 30; i++) begin
         cyc(4, 0, 0);
         if (req) begin
            if (!seen) chk("R9 counter reloaded at expiry", rdata, TO);
            seen = 1;
            hi_cnt++;
         end
      end
      chk("R9 expiry seen", seen, 1);
      chk("R10 request length", hi_cnt, HOLD);
      cyc(4, 32'h0000A5A5, 1);

      tag = "R11";
      cyc(8, 32'hFFFFFFFF, 1);
      cyc(12, 32'hFFFFFFFF, 1);
      cyc(8, 0, 0);
      chk("R11 unmapped read", rdata, 0);
      cyc(0, 0, 0);
      chk("R11 ctrl untouched", rdata, 32'h001);

      tag = "R3";
      cyc(4, 32'h0000A5A5, 1);
      cyc(0, 32'h3, 1);
      cyc(0, 32'h0, 1);
      chk("R3 frozen ctrl ignores write", rdata, 32'h3);
      cyc(4, 32'h5555, 1);
      cyc(0, 32'h100, 1);
      chk("R3 frozen ctrl keeps bad-key", rdata, 32'h103);
      for (int i = 0; i < 5; i++) begin
         idle(10, 4);
         cyc(4, 32'h0000A5A5, 1);
      end
      chk("R3 kicked while frozen no req", req, 0);

      tag = "R4";
      do_reset();
      cyc(0, 0, 0);
      chk("R4 freeze cleared by reset", rdata, 0);

      tag = "R12";
      cyc(0, 32'h2, 1);
      cyc(0, 32'h1, 1);
      idle(30, 4);
      chk("R12 frozen off counter", rdata, TO);
      chk("R12 frozen off no req", req, 0);
      cyc(0, 0, 0);
      chk("R12 ctrl stays frozen off", rdata, 32'h2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule